// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Ramp Sequencer

This block produces the digital reference ramp that a switching regulator's error loop follows during start-up and shutdown. A free-running timebase divides the clock into fixed ticks. Each tick moves a ramp code by one step toward its target, so the slope is set only by the tick period and the step size. Once the ramp reaches full scale the block holds it there and flags that the start-up is complete.

The block takes four clean logic inputs. The first is a power-on-ready level, which is high only when both the supply and the enable pin are above their lockout thresholds. The others are the enable level, a soft-stop control level, and an over-temperature flag. There are two ways to shut down. Lowering the soft-stop control while enabled makes the code ramp down at the same slope it rose, and the gate drivers turn off once the code reaches zero. Losing enable or power-on-ready turns the drivers off and clears the code on the next clock edge, whatever the block was doing. A thermal trip clears the ramp and holds the drivers off. When the flag clears, a new ramp starts from zero on its own.

The default parameters model a 1 us tick, a 0.2 mV step and a 1.5 V full scale (7500 steps in a 13-bit code). The regulated output follows the ramp between 0.15 V and 0.65 V of code value, which gives a fixed 2.5 ms output rise. Over-current and over-voltage protection stay armed for the whole ramp; they live outside this block.

Top module: `softramp_seq`

## Requirements
- R1: While `rst_n` is low, and while `por_ok` or `en` is low, the outputs are `ramp_code`=0, `drv_en`=0, `ramp_done`=0 and `therm_off`=0. Asserting `rst_n` low clears them at once, without waiting for a clock edge.
- R2: While ramping up, `drv_en` is 1 and `ramp_code` starts from 0 and rises by exactly 1 every TICK_CYCLES clocks.
- R3: `ramp_code` never exceeds FULL_SCALE and never wraps below 0. It holds at FULL_SCALE for as long as the ramp stays up. `ramp_done` is 1 only while the code is held at FULL_SCALE, and it goes high within one clock after the code reaches FULL_SCALE.
- R4: If `soft_ctl` is low when the block becomes enabled, `ramp_code` stays 0 and `drv_en` stays 0. When `soft_ctl` goes high, the ramp up starts from 0.
- R5: When `soft_ctl` goes low while the block is enabled, `ramp_code` falls by 1 every TICK_CYCLES clocks (the same slope as the rise) while `drv_en` stays 1. One clock after the code reaches 0, `drv_en` drops and the code stays at 0.
- R6: If `en` or `por_ok` goes low in any state, `drv_en`, `ramp_code` and `ramp_done` are 0 after the next clock edge, with no ramp down. This path takes priority over the thermal path, so `therm_off` is 0 in this case.
- R7: If `ot_flag` goes high while the block is enabled, then after the next clock edge `drv_en` is 0, `ramp_code` is 0 and `therm_off` is 1. They stay that way while the flag is high.
- R8: When `ot_flag` clears, `therm_off` drops. If `soft_ctl` is high, a new ramp starts from 0 without any other stimulus; if it is low, the block waits as in R4.
- R9: If `soft_ctl` goes high again during a ramp down, the code turns around and rises by 1 per tick from the value it had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| por_ok | input | 1 | Power-on-ready: supply and enable both above lockout |
| en | input | 1 | Enable level; low gives an immediate hard off |
| soft_ctl | input | 1 | Soft-stop control: high allows ramp up, low requests ramp down |
| ot_flag | input | 1 | Over-temperature trip, active high |
| ramp_code | output | CODE_W | Reference ramp code, one LSB per step |
| drv_en | output | 1 | Gate-driver enable |
| ramp_done | output | 1 | Ramp complete, holding at full scale |
| therm_off | output | 1 | Thermal shutdown in progress |

## Verification
The main test walks a sequence of input patterns. It covers a normal start with the soft-stop control already high, a delayed start that waits on that control, a gentle stop, a hard stop through enable, a hard stop through power-on-ready, a thermal trip during the hold, and a thermal trip during a ramp down. Each pattern is judged by whether the drivers are on and whether the code reads zero, mid-ramp or full scale. That separates a ramp that is held back from one that is running, and a gentle stop from an immediate one. Further directed steps time the interval between code changes on the way up and on the way down, so a slope mismatch shows up. They also reverse a ramp down in mid-fall and pull reset between clock edges.

// File: rtl/softramp_pkg.sv
package softramp_pkg;

  typedef enum logic [2:0] {
    SQ_OFF      = 3'd0,
    SQ_WAIT_CTL = 3'd1,
    SQ_RISE     = 3'd2,
    SQ_HOLD     = 3'd3,
    SQ_FALL     = 3'd4,
    SQ_THERM    = 3'd5
  } seq_state_e;

  function automatic logic drivers_on(input seq_state_e s);
    return (s == SQ_RISE) || (s == SQ_HOLD) || (s == SQ_FALL);
  endfunction

endpackage

// File: rtl/softramp_rst_sync.sv
module softramp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/softramp_tick.sv
module softramp_tick #(
  parameter int TICK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  generate
    if (TICK_CYCLES <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);
      logic [TW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;

      // R2
      tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/softramp_code.sv
module softramp_code #(
  parameter int CODE_W     = 13,
  parameter int FULL_SCALE = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_zero_o,
  output logic              at_full_o
);

  localparam logic [CODE_W-1:0] FULL_C = CODE_W'(FULL_SCALE);

  logic [CODE_W-1:0] code_q, code_d;
  logic              step_up, step_dn, load;

  assign at_zero_o = (code_q == '0);
  assign at_full_o = (code_q == FULL_C);

  assign step_up = tick_i && up_i && !at_full_o;
  assign step_dn = tick_i && dn_i && !at_zero_o;
  assign load    = clr_i || step_up || step_dn;

  always_comb begin
    code_d = code_q;
    if (clr_i)        code_d = '0;
    else if (step_up) code_d = code_q + 1'b1;
    else if (step_dn) code_d = code_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code_d;
  end

  assign code_o = code_q;

  // R3
  code_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= FULL_C);

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(code_q));

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |->
      (code_q == '0 || code_q == $past(code_q) + 1'b1 || code_q == $past(code_q) - 1'b1));

endmodule

// File: rtl/softramp_ctrl.sv
module softramp_ctrl
  import softramp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic en_i,
  input  logic soft_i,
  input  logic ot_i,
  input  logic at_zero_i,
  input  logic at_full_i,
  output logic clr_o,
  output logic up_o,
  output logic dn_o,
  output logic drv_o,
  output logic done_o,
  output logic therm_o
);

  seq_state_e state_q, state_d;
  logic       kill;

  assign kill = !(por_i && en_i);

  always_comb begin
    state_d = state_q;
    if (kill) begin
      state_d = SQ_OFF;
    end else if (ot_i) begin
      state_d = SQ_THERM;
    end else begin
      unique case (state_q)
        SQ_OFF:      state_d = soft_i ? SQ_RISE : SQ_WAIT_CTL;
        SQ_WAIT_CTL: if (soft_i) state_d = SQ_RISE;
        SQ_RISE: begin
          if (!soft_i)        state_d = SQ_FALL;
          else if (at_full_i) state_d = SQ_HOLD;
        end
        SQ_HOLD:     if (!soft_i) state_d = SQ_FALL;
        SQ_FALL: begin
          if (soft_i)         state_d = SQ_RISE;
          else if (at_zero_i) state_d = SQ_OFF;
        end
        SQ_THERM:    state_d = soft_i ? SQ_RISE : SQ_WAIT_CTL;
        default:     state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_OFF;
    else        state_q <= state_d;
  end

  assign drv_o   = drivers_on(state_q);
  assign up_o    = (state_q == SQ_RISE);
  assign dn_o    = (state_q == SQ_FALL);
  assign done_o  = (state_q == SQ_HOLD);
  assign therm_o = (state_q == SQ_THERM);
  assign clr_o   = kill || ot_i || !drv_o;

  // R6
  hard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!drv_o && !done_o && !therm_o));

  // R7
  therm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_i && !kill) |=> (therm_o && !drv_o));

  // R4
  wait_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT_CTL && !soft_i) |=> !drv_o);

endmodule

// File: rtl/softramp_seq.sv
module softramp_seq #(
  parameter int CODE_W      = 13,
  parameter int FULL_SCALE  = 7500,
  parameter int TICK_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              en,
  input  logic              soft_ctl,
  input  logic              ot_flag,
  output logic [CODE_W-1:0] ramp_code,
  output logic              drv_en,
  output logic              ramp_done,
  output logic              therm_off
);

  localparam logic [CODE_W-1:0] FULL_C = CODE_W'(FULL_SCALE);

  logic rst_s_n, tick, clr, up, dn, at_zero, at_full;

  softramp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  softramp_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (tick)
  );

  softramp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .por_i     (por_ok),
    .en_i      (en),
    .soft_i    (soft_ctl),
    .ot_i      (ot_flag),
    .at_zero_i (at_zero),
    .at_full_i (at_full),
    .clr_o     (clr),
    .up_o      (up),
    .dn_o      (dn),
    .drv_o     (drv_en),
    .done_o    (ramp_done),
    .therm_o   (therm_off)
  );

  softramp_code #(.CODE_W(CODE_W), .FULL_SCALE(FULL_SCALE)) u_code (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick_i    (tick),
    .clr_i     (clr),
    .up_i      (up),
    .dn_i      (dn),
    .code_o    (ramp_code),
    .at_zero_o (at_zero),
    .at_full_o (at_full)
  );

  // R3
  done_at_full_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ramp_done |-> (ramp_code == FULL_C));

  // R5
  drv_off_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(drv_en) |-> (ramp_code == '0));

endmodule

// File: tb/sim_softramp_seq.sv
module sim_softramp_seq;

  localparam int FS = 40;
  localparam int TK = 4;
  localparam int CW = 13;
  localparam int NV = 20;

  // {por, en, soft, ot, wait[9:0], exp_drv, exp_done, exp_therm, exp_class[1:0]}
  // class: 0 = code zero, 1 = code at full scale, 2 = strictly between
  localparam logic [18:0] VEC [NV] = '{
    {4'b0000, 10'd8,   3'b000, 2'd0},
    {4'b0110, 10'd20,  3'b000, 2'd0},
    {4'b1100, 10'd40,  3'b000, 2'd0},
    {4'b1110, 10'd40,  3'b100, 2'd2},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b1100, 10'd40,  3'b100, 2'd2},
    {4'b1100, 10'd200, 3'b000, 2'd0},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b1010, 10'd2,   3'b000, 2'd0},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b0110, 10'd2,   3'b000, 2'd0},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b1111, 10'd2,   3'b001, 2'd0},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b1100, 10'd40,  3'b100, 2'd2},
    {4'b1101, 10'd2,   3'b001, 2'd0},
    {4'b1100, 10'd20,  3'b000, 2'd0},
    {4'b1110, 10'd200, 3'b110, 2'd1},
    {4'b1111, 10'd40,  3'b001, 2'd0},
    {4'b0011, 10'd4,   3'b000, 2'd0}
  };

  function automatic string tag(input int i);
    case (i)
      0, 1:         return "R1";
      2, 3:         return "R4";
      4:            return "R3";
      5, 6, 14:     return "R5";
      7, 9, 11:     return "R2";
      8, 10, 19:    return "R6";
      12, 15, 18:   return "R7";
      default:      return "R8";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n, por_ok, en, soft_ctl, ot_flag;
  logic [CW-1:0] ramp_code;
  logic drv_en, ramp_done, therm_off;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  softramp_seq #(.CODE_W(CW), .FULL_SCALE(FS), .TICK_CYCLES(TK)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_ok    (por_ok),
    .en        (en),
    .soft_ctl  (soft_ctl),
    .ot_flag   (ot_flag),
    .ramp_code (ramp_code),
    .drv_en    (drv_en),
    .ramp_done (ramp_done),
    .therm_off (therm_off)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_code(input string req, input int v);
    int lim = 0;
    while (int'(ramp_code) != v && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    if (lim >= 2000) chk(req, "code reach timeout", int'(ramp_code), v);
  endtask

  function automatic int cls();
    if (ramp_code == '0) return 0;
    if (int'(ramp_code) == FS) return 1;
    return 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; por_ok = 1'b0; en = 1'b0; soft_ctl = 1'b0; ot_flag = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset code", int'(ramp_code), 0);
    chk("R1", "reset drv", int'(drv_en), 0);
    chk("R1", "reset done", int'(ramp_done), 0);
    chk("R1", "reset therm", int'(therm_off), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      {por_ok, en, soft_ctl, ot_flag} = v[18:15];
      repeat (int'(v[14:5])) @(negedge clk);
      chk(tag(i), "drv", int'(drv_en), int'(v[4]));
      chk(tag(i), "done", int'(ramp_done), int'(v[3]));
      chk(tag(i), "therm", int'(therm_off), int'(v[2]));
      chk(tag(i), "code class", cls(), int'(v[1:0]));
    end

    // R2: rise slope, one step per TK clocks
    @(negedge clk);
    {por_ok, en, soft_ctl, ot_flag} = 4'b1110;
    wait_code("R2", 1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (int'(ramp_code) == 1 && cnt < 100);
    chk("R2", "rise interval", cnt, TK);
    chk("R2", "rise step", int'(ramp_code), 2);

    // R3: saturation and hold at full scale
    wait_code("R3", FS);
    repeat (100) @(negedge clk);
    chk("R3", "held code", int'(ramp_code), FS);
    chk("R3", "held done", int'(ramp_done), 1);

    // R5: fall slope matches rise
    soft_ctl = 1'b0;
    wait_code("R5", FS - 1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (int'(ramp_code) == FS - 1 && cnt < 100);
    chk("R5", "fall interval", cnt, TK);
    chk("R5", "fall step", int'(ramp_code), FS - 2);
    chk("R5", "drv during fall", int'(drv_en), 1);

    // R9: reversal mid-fall
    wait_code("R9", FS - 4);
    soft_ctl = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (int'(ramp_code) == FS - 4 && cnt < 100);
    chk("R9", "reversed code", int'(ramp_code), FS - 3);

    // R5: drivers drop one clock after reaching zero
    soft_ctl = 1'b0;
    wait_code("R5", 0);
    @(negedge clk);
    chk("R5", "drv after zero", int'(drv_en), 0);
    repeat (10) @(negedge clk);
    chk("R5", "code stays zero", int'(ramp_code), 0);

    // R1: asynchronous reset between edges
    soft_ctl = 1'b1;
    repeat (60) @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    chk("R1", "async reset code", int'(ramp_code), 0);
    chk("R1", "async reset drv", int'(drv_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule